// File: doc/BRIEF.md
# Keyed Watchdog with Reset-Cause Flags

This block is a watchdog timer that software cannot switch off. It counts system clock cycles from the moment the chip leaves reset. If software does not write the key value 55h to the clear register within the configured interval, the block drives a system reset pulse of fixed length. When the pulse ends, the count starts again from zero.

The block also holds a two-bit cause register, which software reads after any reset. Bit 1 is the power-loss flag. Power-up or an accepted external reset sets it, and software clears it. Bit 0 is the resume flag. It tells a resume reset (1) apart from a watchdog reset (0). Software writes to the cause register can only clear bits. An external reset pin is filtered, so a low level counts as a reset only after it has been held for a minimum number of clocks.

The sequencer has two states:
- RUN: the timeout counter advances.
- PULSE: the system reset output is high and the timeout counter is held at zero.

There are two transitions:
- FIRE (RUN to PULSE) is taken on a timeout, a resume request or an accepted external reset.
- RELEASE (PULSE to RUN) is taken after the last pulse cycle.

Power-on reset places the sequencer in PULSE.

Top module: `keyed_wdt`

## Requirements
- R1: While `por_n` is low, and after it rises, `sys_rst` is high, and `rst_flags` reads 2'b10 (bit 1 power-loss set, bit 0 resume clear).
- R2: If the clear register gets no key write for `WDT_CYCLES` consecutive cycles in RUN, `sys_rst` rises on the next cycle.
- R3: A write with `wr_sel`=0 and `wr_data`=8'h55 in RUN restarts the interval. The following cycle counts as cycle 0 of a new window.
- R4: A write of any value other than 8'h55 to the clear register has no effect, and no write stops the watchdog.
- R5: Every reset pulse lasts exactly `PULSE_LEN` (default 16) cycles. After it, the watchdog times out again `WDT_CYCLES` cycles later unless it is kicked.
- R6: A watchdog timeout clears bit 0 of `rst_flags` and leaves bit 1 unchanged.
- R7: A resume request (`resume_req` high in RUN) starts a reset pulse, sets bit 0 of `rst_flags` and leaves bit 1 unchanged.
- R8: A write with `wr_sel`=1 in RUN sets `rst_flags` to `rst_flags & wr_data[1:0]`. It never sets a bit.
- R9: `ext_rst_n` held low for `EXT_MIN` (default 10) consecutive cycles starts a reset pulse and sets `rst_flags` to 2'b10. A shorter low level has no effect.
- R10: While `sys_rst` is high, resume requests, key writes and flag writes are ignored.
- R11: When several causes arrive in the same RUN cycle, the external reset wins over a resume request, and a resume request wins over a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset level, active low, synchronous to clk |
| resume_req | input | 1 | Resume reset request, one cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the clear register, 1 selects the cause register |
| wr_data | input | 8 | Write data |
| sys_rst | output | 1 | System reset pulse, active high |
| rst_flags | output | 2 | Bit 1 power-loss flag, bit 0 resume flag |

## Verification
The assertions assume two things about the inputs:
- `ext_rst_n`, `resume_req` and the write port are synchronous to `clk` and hold known values outside power-on reset.
- `por_n` is the only asynchronous input.

The stimulus changes every input on the falling clock edge only, so the sampled values are stable at the rising edge. It releases `por_n` away from the rising edge.

Some corner cases are driven on purpose:
- key writes near the end of the window;
- external low levels one cycle too short, then exactly long enough;
- causes that coincide with each other;
- requests that arrive during a pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] WDT_KEY = 8'h55;

    typedef enum logic {
        WS_RUN   = 1'b0,
        WS_PULSE = 1'b1
    } wdt_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_TIMEOUT = 2'd1,
        CAUSE_RESUME  = 2'd2,
        CAUSE_EXT     = 2'd3
    } wdt_cause_e;
endpackage

// File: rtl/wdt_ext_filter.sv
module wdt_ext_filter #(
    parameter int EXT_MIN = 10
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    output logic accept
);
    localparam int CW = $clog2(EXT_MIN + 1);

    logic [CW-1:0] low_q;

    // Count consecutive low cycles; saturate so a held pin fires once.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            low_q <= '0;
        else if (ext_rst_n)
            low_q <= '0;
        else if (low_q != CW'(EXT_MIN))
            low_q <= low_q + 1'b1;
    end

    assign accept = !ext_rst_n && (low_q == CW'(EXT_MIN - 1));

    p_accept_once_r9: assert property (@(posedge clk) disable iff (!por_n)
        accept |=> !accept);
endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
    parameter int LIMIT = 900000
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    assign expire = run && !kick && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (!run || kick || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q < CW'(LIMIT));
    p_kick_restart_r3: assert property (@(posedge clk) disable iff (!por_n)
        (run && kick) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       expire,
    input  logic       resume_req,
    input  logic       ext_acc,
    output wdt_state_e state,
    output logic       fire,
    output wdt_cause_e cause,
    output logic       sys_rst
);
    localparam int PW = $clog2(PULSE_LEN);

    wdt_state_e    state_q, state_d;
    logic [PW-1:0] pcnt_q;

    // State register and pulse counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= WS_PULSE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= (state_q == WS_PULSE && state_d == WS_PULSE) ? pcnt_q + 1'b1 : '0;
        end
    end

    // Next state: FIRE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_RUN:   if (fire) state_d = WS_PULSE;
            WS_PULSE: if (pcnt_q == PW'(PULSE_LEN - 1)) state_d = WS_RUN;
        endcase
    end

    // Outputs: cause priority external > resume > timeout
    always_comb begin
        if (ext_acc)         cause = CAUSE_EXT;
        else if (resume_req) cause = CAUSE_RESUME;
        else if (expire)     cause = CAUSE_TIMEOUT;
        else                 cause = CAUSE_NONE;
        fire    = (state_q == WS_RUN) && (cause != CAUSE_NONE);
        sys_rst = (state_q == WS_PULSE);
    end

    assign state = state_q;

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WS_PULSE && pcnt_q == PW'(PULSE_LEN - 1)) |=> (state_q == WS_RUN));
    p_timeout_fires_r2: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WS_RUN && expire) |=> (state_q == WS_PULSE));
    p_pulse_starts_clean_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> (pcnt_q == '0));
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       fire,
    input  wdt_cause_e cause,
    input  logic       frozen,
    input  logic       wr_flag,
    input  logic [1:0] wr_bits,
    output logic [1:0] flags
);
    logic [1:0] flags_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flags_q <= 2'b10;
        else if (fire) begin
            unique case (cause)
                CAUSE_EXT:     flags_q <= 2'b10;
                CAUSE_RESUME:  flags_q <= {flags_q[1], 1'b1};
                CAUSE_TIMEOUT: flags_q <= {flags_q[1], 1'b0};
                default:       flags_q <= flags_q;
            endcase
        end else if (!frozen && wr_flag)
            flags_q <= flags_q & wr_bits;
    end

    assign flags = flags_q;

    p_sw_clear_only_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wr_flag && !fire) |=> ((flags_q & ~$past(flags_q)) == 2'b00));
    p_pulse_frozen_r10: assert property (@(posedge clk) disable iff (!por_n)
        frozen |=> $stable(flags_q));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int WDT_CYCLES = 900000,
    parameter int PULSE_LEN  = 16,
    parameter int EXT_MIN    = 10
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       resume_req,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       sys_rst,
    output logic [1:0] rst_flags
);
    wdt_state_e state;
    wdt_cause_e cause;
    logic       fire, expire, ext_acc, running, kick, wr_flag;

    assign running = (state == WS_RUN);
    assign kick    = wr_en && !wr_sel && (wr_data == WDT_KEY);
    assign wr_flag = wr_en && wr_sel;

    wdt_ext_filter #(.EXT_MIN(EXT_MIN)) u_filter (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .accept(ext_acc)
    );

    wdt_timeout_ctr #(.LIMIT(WDT_CYCLES)) u_ctr (
        .clk(clk), .por_n(por_n), .run(running), .kick(kick), .expire(expire)
    );

    wdt_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
        .clk(clk), .por_n(por_n), .expire(expire), .resume_req(resume_req),
        .ext_acc(ext_acc), .state(state), .fire(fire), .cause(cause), .sys_rst(sys_rst)
    );

    wdt_flags u_flags (
        .clk(clk), .por_n(por_n), .fire(fire), .cause(cause), .frozen(sys_rst),
        .wr_flag(wr_flag), .wr_bits(wr_data[1:0]), .flags(rst_flags)
    );

    p_no_disable_r4: assert property (@(posedge clk) disable iff (!por_n)
        (running && expire) |=> sys_rst);
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 40;
    localparam int PLEN       = 16;
    localparam int EXT_MIN    = 10;

    logic       clk = 1'b0;
    logic       por_n;
    logic       ext_rst_n = 1'b1;
    logic       resume_req = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    wire        sys_rst;
    wire  [1:0] rst_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyed_wdt #(.WDT_CYCLES(LIMIT), .PULSE_LEN(PLEN), .EXT_MIN(EXT_MIN)) i_keyed_wdt (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .resume_req(resume_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sys_rst(sys_rst), .rst_flags(rst_flags)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Behavioural reference model
    int m_pulse = 1, m_pcnt = 0, m_wcnt = 0, m_flags = 2, m_low = 0;

    always @(posedge clk) begin
        bit acc, kick, expd;
        if (!por_n) begin
            m_pulse = 1; m_pcnt = 0; m_wcnt = 0; m_flags = 2; m_low = 0;
        end else begin
            acc = (!ext_rst_n && m_low == EXT_MIN - 1);
            if (ext_rst_n) m_low = 0;
            else if (m_low < EXT_MIN) m_low = m_low + 1;
            if (m_pulse != 0) begin
                m_wcnt = 0;
                if (m_pcnt == PLEN - 1) begin m_pulse = 0; m_pcnt = 0; end
                else m_pcnt = m_pcnt + 1;
            end else begin
                kick = wr_en && !wr_sel && (wr_data == 8'h55);
                expd = !kick && (m_wcnt == LIMIT - 1);
                if (acc) m_flags = 2;
                else if (resume_req) m_flags = (m_flags & 2) | 1;
                else if (expd) m_flags = m_flags & 2;
                else if (wr_en && wr_sel) m_flags = m_flags & int'(wr_data[1:0]);
                if (acc || resume_req || expd) begin
                    m_pulse = 1; m_pcnt = 0; m_wcnt = 0;
                end else
                    m_wcnt = kick ? 0 : m_wcnt + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            check(cur_req, int'(sys_rst), m_pulse, "sys_rst vs model");
            check(cur_req, int'(rst_flags), m_flags, "rst_flags vs model");
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (sys_rst === 1'b1) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        int n;
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(sys_rst), 1, "sys_rst during por");
        check("R1", int'(rst_flags), 2, "flags after por");
        por_n = 1'b1;
        count_high(n);
        check("R5", n, PLEN, "pulse length after por (R1)");

        // R8: flag writes cannot set bits
        cur_req = "R8";
        wr_en = 1; wr_sel = 1; wr_data = 8'hFF;
        @(negedge clk); check("R8", int'(rst_flags), 2, "write FF sets nothing");
        wr_data = 8'hFE;
        @(negedge clk); check("R8", int'(rst_flags), 2, "write FE keeps bit1");
        wr_en = 0;

        // R3: periodic key writes keep the chip out of reset
        cur_req = "R3";
        for (int k = 0; k < 6; k++) begin
            repeat (30) @(negedge clk);
            wr_en = 1; wr_sel = 0; wr_data = 8'h55;
            @(negedge clk);
            wr_en = 0;
        end
        check("R3", int'(sys_rst), 0, "no reset while kicked");

        // R4 / R2: wrong keys do not restart; timeout after LIMIT cycles
        cur_req = "R4";
        wr_en = 1; wr_sel = 0; wr_data = 8'h55;
        n = 0;
        forever begin
            @(negedge clk);
            if (sys_rst) break;
            n++;
            wr_en = (n % 7 == 3); wr_sel = 0;
            wr_data = (n % 2 == 1) ? 8'h54 : 8'hAA;
            if (n == 38) begin wr_en = 1; wr_data = 8'h00; end
        end
        wr_en = 0;
        check("R2", n, LIMIT, "cycles from kick to timeout (R4)");
        check("R6", int'(rst_flags), 2, "timeout keeps bit1, clears bit0");

        // R10: requests during pulse ignored
        cur_req = "R10";
        resume_req = 1; wr_en = 1; wr_sel = 1; wr_data = 8'h00;
        @(negedge clk);
        resume_req = 0; wr_sel = 0; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 0;
        count_high(n);
        check("R10", n, PLEN - 2, "pulse remainder unchanged");
        check("R10", int'(rst_flags), 2, "flags untouched in pulse");

        // R7: resume reset
        cur_req = "R7";
        resume_req = 1;
        @(negedge clk);
        resume_req = 0;
        check("R7", int'(sys_rst), 1, "resume starts pulse");
        check("R7", int'(rst_flags), 3, "resume sets bit0, keeps bit1");
        count_high(n);
        check("R5", n, PLEN, "resume pulse length");
        cur_req = "R8";
        wr_en = 1; wr_sel = 1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 0;
        check("R8", int'(rst_flags), 1, "software clears bit1");

        // R6: watchdog reset clears bit0
        cur_req = "R6";
        while (!sys_rst) @(negedge clk);
        check("R6", int'(rst_flags), 0, "timeout clears bit0");
        count_high(n);

        // R9: short external low ignored, full length accepted
        cur_req = "R9";
        ext_rst_n = 0;
        repeat (EXT_MIN - 1) @(negedge clk);
        ext_rst_n = 1;
        @(negedge clk);
        check("R9", int'(sys_rst), 0, "short external low ignored");
        check("R9", int'(rst_flags), 0, "short external low flags");
        cur_req = "R11";
        for (int i = 0; i < EXT_MIN; i++) begin
            ext_rst_n = 0;
            resume_req = (i == EXT_MIN - 1);
            @(negedge clk);
        end
        ext_rst_n = 1; resume_req = 0;
        check("R9", int'(sys_rst), 1, "external reset accepted");
        check("R11", int'(rst_flags), 2, "external wins over resume");
        count_high(n);
        check("R5", n, PLEN, "external pulse length");
        repeat (5) @(negedge clk);
        report();
    end
endmodule